// File: doc/BRIEF.md
# Banked Change-of-State Interrupt Unit

This block watches a wide vector of digital inputs that have already been synchronized to its clock. It groups them into banks of 32 channels. Each cycle it compares every input with its value one cycle earlier. A bank raises its own pending flag when at least one of its channels changes level, in either direction, and that channel is selected in the bank's channel mask and the bank is enabled. The same clock edge that sets the flag also copies the bank's 32 input bits into a snapshot register. The snapshot stays frozen until software clears that bank.

Software reaches the block through a small register port. Each bank has three registers: a channel mask, a read-only snapshot and a write-only clear strobe. There is also a global enable register with one bit per bank, which reads back, and a read-only pending-status word. A single interrupt line is high whenever any bank is pending.

Top module: `cos_irq_unit`

## Requirements
- R1: After reset the enable register, status word, every snapshot and the interrupt line are all zero. No bank can become pending until its enable bit is written to 1.
- R2: A low-to-high change on a channel whose mask bit is 1, in an enabled bank, sets that bank's status bit. The status bit is visible after the clock edge that first sees the new input value.
- R3: A high-to-low change under the same conditions sets the status bit in the same way.
- R4: A change on a channel whose mask bit is 0 does not set the bank's status bit.
- R5: A change in a bank whose enable bit is 0 does not set that bank's status bit, even when the channel's mask bit is 1.
- R6: When a bank's status bit is set, its snapshot holds the bank's 32 input bits as they stood at the setting edge, with input 32*b+i in bit i.
- R7: While a bank is pending, further input changes leave its snapshot unchanged.
- R8: A write of 1 in bit 0 to a bank's clear register clears that bank's status bit and its snapshot. A write with bit 0 equal to 0 has no effect.
- R9: The interrupt output is 1 exactly when at least one status bit is 1.
- R10: Register map: addr[MSB]=0 selects bank addr[MSB-1:2]. Within that bank, low bits 0 are the mask (read/write), 1 the snapshot (read-only) and 2 the clear strobe. addr[MSB]=1 with low bits 0 is the enable register (bit b = bank b, read/write); with low bits 1 it is the status word (bit b = bank b). The mask and enable registers read back what was written. Unused locations read as 0.
- R11: When a clear and a qualifying change reach the same bank in the same cycle, the bank stays pending and its snapshot takes the new input value.
- R12: Banks are independent. An event in one bank changes neither the status bit nor the snapshot of any other bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| din | input | NUM_BANKS*32 | Synchronized input channels |
| wr_en | input | 1 | Register write strobe |
| addr | input | BIDX_W+3 | Register address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data, combinational from addr |
| irq | output | 1 | Combined interrupt, OR of pending banks |

## Verification
The bench builds the unit with three banks, so the address index is two bits wide and one index value has no bank behind it. This makes it possible to show that a disabled third bank stays silent while two enabled neighbours interrupt. A table of mask and edge patterns drives bank 0 through both edge directions, through masked-out channels and through snapshot contents. Directed cases then cover reset, independence between banks, snapshot freezing while pending, a clear strobe with bit 0 at zero, and a clear that meets a fresh change in the same cycle.

// File: rtl/cos_pkg.sv
package cos_pkg;
  localparam int unsigned COS_BANK_W = 32;
  typedef logic [COS_BANK_W-1:0] bank_word_t;

  typedef enum logic [1:0] {
    SEL_MASK  = 2'd0,
    SEL_LATCH = 2'd1,
    SEL_CLEAR = 2'd2,
    SEL_NONE  = 2'd3
  } bank_sel_e;

  typedef enum logic [1:0] {
    GSEL_ENABLE = 2'd0,
    GSEL_STATUS = 2'd1,
    GSEL_RSV2   = 2'd2,
    GSEL_RSV3   = 2'd3
  } glob_sel_e;

  // channels that toggled since last cycle and are selected
  function automatic bank_word_t qualified_toggles(bank_word_t cur, bank_word_t prev,
                                                   bank_word_t mask, logic bank_on);
    return (cur ^ prev) & mask & {COS_BANK_W{bank_on}};
  endfunction

  // a new snapshot is taken if the bank is idle or is being cleared now
  function automatic logic snapshot_allowed(logic evt, logic pending, logic clr);
    return evt && (!pending || clr);
  endfunction
endpackage

// File: rtl/cos_bank.sv
module cos_bank
  import cos_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  bank_word_t din_cur,
  input  bank_word_t din_prev,
  input  logic       bank_on,
  input  logic       mask_we,
  input  bank_word_t wdata,
  input  logic       clr,
  output bank_word_t mask,
  output bank_word_t snap,
  output logic       pending,
  output logic       evt
);
  bank_word_t hits;
  logic       take;

  assign hits = qualified_toggles(din_cur, din_prev, mask, bank_on);
  assign evt  = |hits;
  assign take = snapshot_allowed(evt, pending, clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
    end else if (mask_we) begin
      mask <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      snap    <= '0;
    end else begin
      if (clr) begin
        pending <= 1'b0;
        snap    <= '0;
      end
      if (take) begin
        pending <= 1'b1;
        snap    <= din_cur;
      end
    end
  end
endmodule

// File: rtl/cos_regif.sv
module cos_regif
  import cos_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BIDX_W    = 2,
  localparam int unsigned ADDR_W   = BIDX_W + 3,
  localparam int unsigned FLAT_W   = NUM_BANKS * COS_BANK_W
) (
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wbit0,
  input  logic [FLAT_W-1:0]    mask_all,
  input  logic [FLAT_W-1:0]    snap_all,
  input  logic [NUM_BANKS-1:0] enable,
  input  logic [NUM_BANKS-1:0] status,
  output logic [NUM_BANKS-1:0] mask_we,
  output logic [NUM_BANKS-1:0] clr_hit,
  output logic                 en_we,
  output logic [31:0]          rdata
);
  logic              is_glob;
  logic [BIDX_W-1:0] bidx;
  logic [1:0]        sel;

  assign is_glob = addr[ADDR_W-1];
  assign bidx    = addr[ADDR_W-2:2];
  assign sel     = addr[1:0];
  assign en_we   = wr_en && is_glob && (sel == GSEL_ENABLE);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec
    logic here;
    assign here       = !is_glob && (bidx == BIDX_W'(b));
    assign mask_we[b] = wr_en && here && (sel == SEL_MASK);
    assign clr_hit[b] = wr_en && here && (sel == SEL_CLEAR) && wbit0;
  end

  always_comb begin
    rdata = '0;
    if (is_glob) begin
      case (sel)
        GSEL_ENABLE: rdata[NUM_BANKS-1:0] = enable;
        GSEL_STATUS: rdata[NUM_BANKS-1:0] = status;
        default:     rdata = '0;
      endcase
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (bidx == BIDX_W'(b)) begin
          case (sel)
            SEL_MASK:  rdata = mask_all[b*COS_BANK_W +: COS_BANK_W];
            SEL_LATCH: rdata = snap_all[b*COS_BANK_W +: COS_BANK_W];
            default:   rdata = '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/cos_irq_unit.sv
module cos_irq_unit
  import cos_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  localparam int unsigned BIDX_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int unsigned ADDR_W   = BIDX_W + 3,
  localparam int unsigned FLAT_W   = NUM_BANKS * COS_BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAT_W-1:0] din,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq
);
  logic [FLAT_W-1:0]    din_q;
  logic [FLAT_W-1:0]    mask_all;
  logic [FLAT_W-1:0]    latch_all;
  logic [NUM_BANKS-1:0] enable;
  logic [NUM_BANKS-1:0] status;
  logic [NUM_BANKS-1:0] bank_evt;
  logic [NUM_BANKS-1:0] clr_hit;
  logic [NUM_BANKS-1:0] mask_we;
  logic                 en_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) din_q <= '0;
    else        din_q <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     enable <= '0;
    else if (en_we) enable <= wdata[NUM_BANKS-1:0];
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    cos_bank u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .din_cur (din[b*COS_BANK_W +: COS_BANK_W]),
      .din_prev(din_q[b*COS_BANK_W +: COS_BANK_W]),
      .bank_on (enable[b]),
      .mask_we (mask_we[b]),
      .wdata   (wdata),
      .clr     (clr_hit[b]),
      .mask    (mask_all[b*COS_BANK_W +: COS_BANK_W]),
      .snap    (latch_all[b*COS_BANK_W +: COS_BANK_W]),
      .pending (status[b]),
      .evt     (bank_evt[b])
    );
  end

  cos_regif #(.NUM_BANKS(NUM_BANKS), .BIDX_W(BIDX_W)) u_regif (
    .wr_en   (wr_en),
    .addr    (addr),
    .wbit0   (wdata[0]),
    .mask_all(mask_all),
    .snap_all(latch_all),
    .enable  (enable),
    .status  (status),
    .mask_we (mask_we),
    .clr_hit (clr_hit),
    .en_we   (en_we),
    .rdata   (rdata)
  );

  assign irq = |status;
endmodule

// File: rtl/cos_irq_chk.sv
module cos_irq_chk #(
  parameter int unsigned NUM_BANKS = 4,
  localparam int unsigned FLAT_W   = NUM_BANKS * 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 irq,
  input logic [NUM_BANKS-1:0] status,
  input logic [NUM_BANKS-1:0] enable,
  input logic [NUM_BANKS-1:0] bank_evt,
  input logic [NUM_BANKS-1:0] clr_hit,
  input logic [FLAT_W-1:0]    latch_all
);
  // R2
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(bank_evt) != '0));

  // R8
  irq_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> ($past(clr_hit) != '0));

  // R8
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status) & ~status & ~$past(clr_hit)) == '0);

  // R5
  status_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status)) & ~$past(enable)) == '0);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_snap
    // R7
    snap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(status[b]) && !$past(clr_hit[b])) |-> $stable(latch_all[b*32 +: 32]));
  end
endmodule

bind cos_irq_unit cos_irq_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq      (irq),
  .status   (status),
  .enable   (enable),
  .bank_evt (bank_evt),
  .clr_hit  (clr_hit),
  .latch_all(latch_all)
);

// File: tb/sim_cos_irq_unit.sv
module sim_cos_irq_unit;
  localparam int unsigned NB     = 3;
  localparam int unsigned BW     = 2;
  localparam int unsigned AW     = BW + 3;
  localparam int unsigned DW     = NB * 32;
  localparam int unsigned NVEC   = 5;

  // {mask, din_before, din_after, expect_pending, expect_snapshot}
  localparam logic [128:0] VEC [NVEC] = '{
    {32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0001, 1'b1, 32'h0000_0001},
    {32'hFFFF_FFFF, 32'h8000_0000, 32'h0000_0000, 1'b1, 32'h0000_0000},
    {32'h0000_FFFF, 32'h0000_0000, 32'hFFFF_0000, 1'b0, 32'h0000_0000},
    {32'h00F0_0000, 32'hA5A5_A5A5, 32'hA5B5_A5A5, 1'b1, 32'hA5B5_A5A5},
    {32'h0000_0100, 32'hFFFF_FFFF, 32'hFFFF_FEFF, 1'b1, 32'hFFFF_FEFF}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] din = '0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  cos_irq_unit #(.NUM_BANKS(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .din(din), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  function automatic logic [AW-1:0] baddr(int b, int sel);
    return {1'b0, BW'(b), 2'(sel)};
  endfunction
  function automatic logic [AW-1:0] gaddr(int sel);
    return {1'b1, {BW{1'b0}}, 2'(sel)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic set_bank(int b, logic [31:0] v);
    din[b*32 +: 32] = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(gaddr(0), r); check("R1 enable", r, 32'h0);
    rd(gaddr(1), r); check("R1 status", r, 32'h0);
    rd(baddr(0, 1), r); check("R1 snapshot", r, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);

    // R1 no interrupt before enable, mask all set
    wr(baddr(0, 0), 32'hFFFF_FFFF);
    set_bank(0, 32'h0000_00FF);
    set_bank(0, 32'h0000_0000);
    rd(gaddr(1), r); check("R1 disabled after reset", r, 32'h0);

    // table walk on bank 0 (R2 R3 R4 R6 R9)
    wr(gaddr(0), 32'h1);
    for (int i = 0; i < NVEC; i++) begin
      logic [128:0] v;
      v = VEC[i];
      wr(baddr(0, 0), v[128:97]);
      wr_en = 1'b0;
      din[31:0] = 32'h0;
      @(negedge clk);
      wr(baddr(0, 0), 32'h0);
      set_bank(0, v[96:65]);
      @(negedge clk);
      wr(baddr(0, 2), 32'h1);
      wr(baddr(0, 0), v[128:97]);
      set_bank(0, v[64:33]);
      rd(gaddr(1), r); check($sformatf("R2/R3/R4 vec%0d status", i), r, {31'h0, v[32]});
      rd(baddr(0, 1), r); check($sformatf("R6 vec%0d snapshot", i), r, v[31:0]);
      check($sformatf("R9 vec%0d irq", i), {31'h0, irq}, {31'h0, v[32]});
      wr(baddr(0, 2), 32'h1);
    end

    // R12 independence, R5 disabled bank 2
    wr(baddr(0, 0), 32'h0);
    wr(gaddr(0), 32'h3);
    wr(baddr(1, 0), 32'hFFFF_FFFF);
    wr(baddr(2, 0), 32'hFFFF_FFFF);
    set_bank(1, 32'h0000_0020);
    rd(gaddr(1), r); check("R12 only bank1 pending", r, 32'h2);
    rd(baddr(0, 1), r); check("R12 bank0 snapshot untouched", r, 32'h0);
    rd(baddr(1, 1), r); check("R6 bank1 snapshot", r, 32'h0000_0020);
    set_bank(2, 32'h1234_5678);
    rd(gaddr(1), r); check("R5 disabled bank2 silent", r, 32'h2);
    rd(baddr(2, 1), r); check("R5 bank2 snapshot", r, 32'h0);

    // R7 snapshot frozen while pending
    set_bank(1, 32'hFFFF_0000);
    rd(baddr(1, 1), r); check("R7 frozen snapshot", r, 32'h0000_0020);

    // R10 readback
    rd(gaddr(0), r); check("R10 enable readback", r, 32'h3);
    rd(baddr(1, 0), r); check("R10 mask readback", r, 32'hFFFF_FFFF);
    rd(baddr(1, 3), r); check("R10 unused location", r, 32'h0);

    // R8 clear with bit0 = 0 has no effect
    wr(baddr(1, 2), 32'hFFFF_FFFE);
    rd(gaddr(1), r); check("R8 clear bit0=0 ignored", r, 32'h2);
    rd(baddr(1, 1), r); check("R8 snapshot kept", r, 32'h0000_0020);
    wr(baddr(1, 2), 32'h1);
    rd(gaddr(1), r); check("R8 status cleared", r, 32'h0);
    rd(baddr(1, 1), r); check("R8 snapshot cleared", r, 32'h0);
    check("R9 irq low after clear", {31'h0, irq}, 32'h0);

    // R11 clear meets new change in same cycle
    set_bank(1, 32'h0000_0001);
    rd(gaddr(1), r); check("R11 pending before", r, 32'h2);
    wr_en = 1'b1; addr = baddr(1, 2); wdata = 32'h1;
    din[63:32] = 32'h0000_0003;
    @(negedge clk);
    wr_en = 1'b0;
    rd(gaddr(1), r); check("R11 still pending", r, 32'h2);
    rd(baddr(1, 1), r); check("R11 new snapshot", r, 32'h0000_0003);
    check("R9 irq high", {31'h0, irq}, 32'h1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule